// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block generates all refresh activity for an asynchronous DRAM whose row counter is internal. After reset it waits out a fixed power-up pause, then runs a wake-up burst of refresh cycles, and from then on issues one refresh per refresh interval. Every refresh uses CAS-before-RAS ordering, so no address is driven: the DRAM's own counter selects the row.

The sequencer shares the DRAM strobes with an access controller through a request/grant pair. It raises `bus_req`, waits for `bus_gnt`, drives `ras_n` and `cas_n` for a whole refresh cycle including precharge, and then drops `bus_req`. The handshake rules are: the sequencer holds `bus_req` high until its work is done and never withdraws it early; the access controller must keep `bus_gnt` high from when it grants until `bus_req` falls. During the wake-up burst one request covers every cycle of the burst. A refresh request that waits longer than a configured slack for its grant counts as a missed deadline. The block then lowers `init_done` and repeats the whole wake-up burst.

Timing parameters are given in nanoseconds or microseconds together with the clock frequency, and are converted to clock cycles by rounding up. The precharge time is stretched when needed, so that one RAS fall never follows the previous one closer than the minimum cycle time.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low, `bus_req` and `init_done` are 0 and `ras_n` and `cas_n` are 1.
- R2: After reset is released, `bus_req` stays low and both strobes stay high until PWRUP_US·CLK_MHZ clock edges have passed.
- R3: `ras_n` or `cas_n` is low only while both `bus_req` and `bus_gnt` are high.
- R4: In each refresh, `cas_n` falls first and stays low alone for ceil(CSR_NS·CLK_MHZ/1000) cycles. Then `ras_n` is low for ceil(RAS_NS·CLK_MHZ/1000) cycles, and `cas_n` rises on the same cycle as `ras_n`.
- R5: Two successive falls of `ras_n` are never closer than ceil(MIN_RC_NS·CLK_MHZ/1000) cycles.
- R6: After the power-up pause, exactly BURST_LEN refreshes run under one held request. `init_done` rises on the same cycle that `bus_req` falls after the last of them.
- R7: Once initialised, `bus_req` rises every ceil(REFI_NS·CLK_MHZ/1000) cycles. Each such request carries exactly one refresh and then falls.
- R8: Once raised, `bus_req` stays high until the refresh cycle it is waiting for, or the last cycle of the burst, has finished.
- R9: If a periodic request waits about ceil(SLACK_NS·CLK_MHZ/1000) cycles without grant, `init_done` falls. A fresh burst of BURST_LEN refreshes then runs, and `init_done` returns high after it.
- R10: `bus_gnt` asserted while `bus_req` is low has no effect: both strobes stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | output | 1 | Request for the DRAM strobes |
| bus_gnt | input | 1 | Grant from the access controller |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| init_done | output | 1 | High once the wake-up burst is complete and no repeat burst is running |

## Verification
Every cycle, the embedded properties check the following: the strobes move only under a held grant, CAS leads RAS and rises with it, RAS falls keep their minimum spacing, the request is not dropped early, and `init_done` stays low through any burst and after an overrun. The bench's scenarios are needed to show the cycle counts. These are the length of the power-up pause, the exact number of refreshes in each burst, the period between periodic requests, the width of each pulse, and how long the deadline tolerates a withheld grant before the burst repeats.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    SQ_PWRUP = 2'd0,
    SQ_BURST = 2'd1,
    SQ_RUN   = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_LOW  = 2'd2,
    PH_PRE  = 2'd3
  } cbr_phase_e;

  // Round a time in ns up to whole clock cycles.
  function automatic int ns2cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/ref_deadline_timer.sv
module ref_deadline_timer #(
  parameter int INTERVAL_CYC = 3120,
  parameter int SLACK_CYC    = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic served,
  input  logic ack,
  output logic due,
  output logic overrun
);
  localparam int IW = $clog2(INTERVAL_CYC + 1);
  localparam int SW = $clog2(SLACK_CYC + 1);

  logic [IW-1:0] ivl_cnt;
  logic [SW-1:0] wait_cnt;
  logic          in_svc;
  logic          tick;
  logic          waiting;

  assign tick    = (ivl_cnt == IW'(INTERVAL_CYC - 1));
  assign waiting = due && !in_svc && !served;
  assign overrun = waiting && (wait_cnt == SW'(SLACK_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ivl_cnt  <= '0;
      wait_cnt <= '0;
      due      <= 1'b0;
      in_svc   <= 1'b0;
    end else begin
      ivl_cnt  <= tick ? '0 : ivl_cnt + 1'b1;
      due      <= (due && !ack) || tick;
      if (ack)         in_svc <= 1'b0;
      else if (served) in_svc <= 1'b1;
      wait_cnt <= waiting ? wait_cnt + 1'b1 : '0;
    end
  end

  // R9
  no_overrun_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !served && !ack);

endmodule

// File: rtl/cbr_cycle_engine.sv
module cbr_cycle_engine
  import dram_ref_pkg::*;
#(
  parameter int LEAD_CYC   = 2,
  parameter int LOW_CYC    = 12,
  parameter int PRE_CYC    = 8,
  parameter int MIN_RC_CYC = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int MAXC = (LEAD_CYC > LOW_CYC) ?
                        ((LEAD_CYC > PRE_CYC) ? LEAD_CYC : PRE_CYC) :
                        ((LOW_CYC > PRE_CYC) ? LOW_CYC : PRE_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam int RW   = $clog2(MIN_RC_CYC + 2);

  cbr_phase_e    phase;
  logic [CW-1:0] cnt;

  assign busy  = (phase != PH_IDLE);
  assign done  = (phase == PH_PRE) && (cnt == CW'(PRE_CYC - 1));
  assign cas_n = !((phase == PH_LEAD) || (phase == PH_LOW));
  assign ras_n = (phase != PH_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin phase <= PH_LEAD; cnt <= '0; end
        PH_LEAD:
          if (cnt == CW'(LEAD_CYC - 1)) begin phase <= PH_LOW; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        PH_LOW:
          if (cnt == CW'(LOW_CYC - 1)) begin phase <= PH_PRE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        PH_PRE:
          if (done) begin phase <= PH_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Spacing monitor for the minimum RAS cycle check.
  logic          ras_q;
  logic          seen_fall;
  logic [RW-1:0] rc_cnt;
  logic          ras_fall;
  assign ras_fall = ras_q && !ras_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      seen_fall <= 1'b0;
      rc_cnt    <= '0;
    end else begin
      ras_q <= ras_n;
      if (ras_fall) begin
        seen_fall <= 1'b1;
        rc_cnt    <= RW'(1);
      end else if (rc_cnt < RW'(MIN_RC_CYC + 1)) begin
        rc_cnt <= rc_cnt + 1'b1;
      end
    end
  end

  // R4
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n && $past(!cas_n));
  // R4
  cas_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $rose(cas_n));
  // R5
  rc_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && seen_fall) |-> (rc_cnt >= RW'(MIN_RC_CYC)));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int CLK_MHZ   = 200,
  parameter int PWRUP_US  = 200,
  parameter int REFI_NS   = 15600,
  parameter int SLACK_NS  = 7800,
  parameter int CSR_NS    = 10,
  parameter int RAS_NS    = 60,
  parameter int RP_NS     = 40,
  parameter int MIN_RC_NS = 110,
  parameter int BURST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic bus_req,
  input  logic bus_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic init_done
);
  localparam int PWRUP_CYC    = PWRUP_US * CLK_MHZ;
  localparam int INTERVAL_CYC = ns2cyc(REFI_NS, CLK_MHZ);
  localparam int SLACK_CYC    = ns2cyc(SLACK_NS, CLK_MHZ);
  localparam int LEAD_CYC     = ns2cyc(CSR_NS, CLK_MHZ);
  localparam int LOW_CYC      = ns2cyc(RAS_NS, CLK_MHZ);
  localparam int RP_CYC       = ns2cyc(RP_NS, CLK_MHZ);
  localparam int MIN_RC_CYC   = ns2cyc(MIN_RC_NS, CLK_MHZ);
  localparam int RP_FLOOR     = MIN_RC_CYC - LEAD_CYC - LOW_CYC;
  localparam int PRE_CYC      = (RP_CYC > RP_FLOOR) ? RP_CYC : RP_FLOOR;
  localparam int PW           = $clog2(PWRUP_CYC + 1);
  localparam int BW           = $clog2(BURST_LEN + 1);

  seq_state_e    state;
  logic [PW-1:0] pw_cnt;
  logic [BW-1:0] burst_cnt;
  logic          req_q;
  logic          init_q;
  logic          start;
  logic          eng_busy;
  logic          eng_done;
  logic          due;
  logic          overrun;
  logic          in_run;

  assign in_run    = (state == SQ_RUN);
  assign start     = req_q && bus_gnt && !eng_busy && (state != SQ_PWRUP);
  assign bus_req   = req_q;
  assign init_done = init_q;

  ref_deadline_timer #(
    .INTERVAL_CYC(INTERVAL_CYC),
    .SLACK_CYC   (SLACK_CYC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (!in_run),
    .served (start),
    .ack    (eng_done && in_run),
    .due    (due),
    .overrun(overrun)
  );

  cbr_cycle_engine #(
    .LEAD_CYC  (LEAD_CYC),
    .LOW_CYC   (LOW_CYC),
    .PRE_CYC   (PRE_CYC),
    .MIN_RC_CYC(MIN_RC_CYC)
  ) u_engine (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (eng_busy),
    .done (eng_done),
    .ras_n(ras_n),
    .cas_n(cas_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_PWRUP;
      pw_cnt    <= '0;
      burst_cnt <= '0;
      req_q     <= 1'b0;
      init_q    <= 1'b0;
    end else begin
      unique case (state)
        SQ_PWRUP: begin
          if (pw_cnt == PW'(PWRUP_CYC - 1)) begin
            state     <= SQ_BURST;
            burst_cnt <= '0;
            req_q     <= 1'b1;
          end else begin
            pw_cnt <= pw_cnt + 1'b1;
          end
        end
        SQ_BURST: begin
          if (eng_done) begin
            if (burst_cnt == BW'(BURST_LEN - 1)) begin
              state  <= SQ_RUN;
              req_q  <= 1'b0;
              init_q <= 1'b1;
            end else begin
              burst_cnt <= burst_cnt + 1'b1;
            end
          end
        end
        SQ_RUN: begin
          if (overrun) begin
            state     <= SQ_BURST;
            burst_cnt <= '0;
            init_q    <= 1'b0;
          end else if (eng_done) begin
            req_q <= 1'b0;
          end else if (due && !req_q) begin
            req_q <= 1'b1;
          end
        end
        default: state <= SQ_PWRUP;
      endcase
    end
  end

  // R2
  pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_PWRUP) |-> (!bus_req && ras_n && cas_n));
  // R3
  strobe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> (bus_req && bus_gnt));
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !eng_done) |=> bus_req);
  // R6
  burst_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_BURST) |-> !init_done);
  // R9
  overrun_reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> (!init_done && bus_req));
  // R10
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (ras_n && cas_n));

endmodule

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;

  localparam int CLK_MHZ   = 200;
  localparam int BURST_LEN = 8;
  // Expected cycle counts, worked out from the requirements.
  localparam int E_PWRUP   = 200;  // 1 us * 200 MHz
  localparam int E_IVL     = 200;  // 1000 ns
  localparam int E_SLACK   = 40;   // 200 ns
  localparam int E_LEAD    = 2;    // 10 ns
  localparam int E_LOW     = 4;    // 20 ns
  localparam int E_MINRC   = 9;    // 45 ns
  localparam int GDLY      = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_gnt = 1'b0;
  logic bus_req, ras_n, cas_n, init_done;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(1), .REFI_NS(1000), .SLACK_NS(200),
    .CSR_NS(10), .RAS_NS(20), .RP_NS(15), .MIN_RC_NS(45), .BURST_LEN(BURST_LEN)
  ) u_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done_run = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard of expected refresh pulses.
  typedef struct { int lead; int low; } pulse_t;
  pulse_t exp_q[$];

  task automatic expect_refreshes(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back('{lead: E_LEAD, low: E_LOW});
  endtask

  // Grant responder.
  bit gnt_block = 1'b0;
  bit gnt_force = 1'b0;
  initial begin
    int wcnt = 0;
    bit auto_g = 1'b0;
    forever begin
      @(negedge clk);
      if (!bus_req) begin
        auto_g = 1'b0;
        wcnt = 0;
      end else if (!gnt_block) begin
        if (wcnt >= GDLY) auto_g = 1'b1;
        else wcnt++;
      end
      bus_gnt = auto_g || gnt_force;
    end
  end

  // Monitor.
  int fall_count = 0;
  int r3_viol    = 0;
  initial begin
    bit ras_p = 1'b1;
    int lead_cnt = 0;
    int low_cnt = 0;
    int cur_lead = 0;
    int since_fall = 0;
    bit have_fall = 1'b0;
    pulse_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        since_fall++;
        if ((!ras_n || !cas_n) && !(bus_req && bus_gnt)) r3_viol++;
        if (!cas_n && ras_n) lead_cnt++;
        else if (cas_n && ras_n) lead_cnt = 0;
        if (ras_p && !ras_n) begin
          fall_count++;
          cur_lead = lead_cnt;
          lead_cnt = 0;
          low_cnt = 1;
          if (have_fall) chk(since_fall >= E_MINRC, "R5 ras fall spacing", since_fall, E_MINRC);
          have_fall = 1'b1;
          since_fall = 0;
        end else if (!ras_n) begin
          low_cnt++;
        end else if (!ras_p && ras_n) begin
          chk(cas_n == 1'b1, "R4 cas rises with ras", int'(cas_n), 1);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected refresh", 1, 0);
          end else begin
            e = exp_q.pop_front();
            chk(cur_lead == e.lead, "R4 cas lead", cur_lead, e.lead);
            chk(low_cnt == e.low, "R4 ras low width", low_cnt, e.low);
          end
        end
        ras_p = ras_n;
      end
    end
  end

  int tcyc = 0;
  task automatic step();
    @(negedge clk);
    tcyc++;
  endtask

  initial begin
    int t0, t1, f0, n;
    // R1 reset state
    repeat (4) @(negedge clk);
    chk(!bus_req, "R1 bus_req in reset", int'(bus_req), 0);
    chk(ras_n && cas_n, "R1 strobes in reset", int'({ras_n, cas_n}), 3);
    chk(!init_done, "R1 init_done in reset", int'(init_done), 0);
    expect_refreshes(BURST_LEN);
    rst_n = 1'b1;

    // R2 power-up pause
    n = 0;
    do begin
      step();
      if (!bus_req) n++;
      if (!ras_n || !cas_n) chk(1'b0, "R2 strobe during pause", 0, 1);
    end while (!bus_req);
    chk(n >= E_PWRUP - 1 && n <= E_PWRUP + 1, "R2 pause length", n, E_PWRUP);

    // R6 wake-up burst
    f0 = fall_count;
    while (!init_done) step();
    chk(fall_count - f0 == BURST_LEN, "R6 burst count", fall_count - f0, BURST_LEN);
    chk(!bus_req, "R6 req falls with init_done", int'(bus_req), 0);

    // R7 periodic refresh
    expect_refreshes(1);
    while (!bus_req) step();
    t0 = tcyc;
    for (int k = 0; k < 3; k++) begin
      f0 = fall_count;
      while (bus_req) step();
      chk(fall_count - f0 == 1, "R7 one refresh per request", fall_count - f0, 1);
      if (k == 0) begin
        // R10 grant without request
        gnt_force = 1'b1;
        for (int i = 0; i < 20; i++) begin
          step();
          if (!bus_req) chk(ras_n && cas_n, "R10 strobes idle under stray grant",
                            int'({ras_n, cas_n}), 3);
        end
        gnt_force = 1'b0;
      end
      expect_refreshes(1);
      while (!bus_req) step();
      t1 = tcyc;
      chk(t1 - t0 == E_IVL, "R7 request period", t1 - t0, E_IVL);
      t0 = t1;
    end
    while (bus_req) step();

    // R9 missed deadline
    gnt_block = 1'b1;
    while (!bus_req) step();
    t0 = tcyc;
    while (init_done) step();
    chk(tcyc - t0 >= E_SLACK - 2 && tcyc - t0 <= E_SLACK + 1, "R9 deadline slack",
        tcyc - t0, E_SLACK);
    chk(bus_req, "R8 request held after overrun", int'(bus_req), 1);
    expect_refreshes(BURST_LEN);
    f0 = fall_count;
    gnt_block = 1'b0;
    while (!init_done) step();
    chk(fall_count - f0 == BURST_LEN, "R9 repeat burst count", fall_count - f0, BURST_LEN);
    chk(!bus_req, "R9 req released after repeat burst", int'(bus_req), 0);

    repeat (10) step();
    chk(exp_q.size() == 0, "R4 all expected refreshes seen", exp_q.size(), 0);
    chk(r3_viol == 0, "R3 strobes only under grant", r3_viol, 0);
    done_run = 1'b1;
  end

  // Watchdog and summary.
  initial begin
    for (int i = 0; i < 150000 && !done_run; i++) @(posedge clk);
    if (!done_run) chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule